// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block is a small programmable logic cell. Its logic function is data: an eight-word by two-bit table, addressed by three logic inputs, gives two independent Boolean functions of those inputs. Each of the two results can go straight to its output pin, or through a flip-flop first. A separate configuration bit per output picks which path is used, so one cell can serve as pure combinational logic, as a registered stage, or as a mix of both.

The table contents and the two path-select bits are written in parallel through a configuration port. They are captured only on a clock edge where the configuration enable is high, and they hold at all other times. The output flip-flops sample the table on every rising edge and clear on a synchronous reset. The reset does not touch the configuration.

Top module: `cfgLutCell`

## Requirements
- R1: The table address is lutIn[2:0], with lutIn[2] as the most significant bit. Table word k sits in cfgTable[2k+1:2k]. Bit 2k drives output 0 and bit 2k+1 drives output 1.
- R2: When the path-select bit of an output is 0, that output equals the table bit for the current address in the same cycle, with no register on the way.
- R3: When the path-select bit of an output is 1, that output equals the table bit for the address that was present just before the most recent rising clock edge.
- R4: The two path-select bits act independently. cfgRegSel[0] chooses the path of output 0 and cfgRegSel[1] chooses the path of output 1.
- R5: After a rising edge with rst high, every output in registered mode reads 0. Outputs in combinational mode keep following the table, and the stored configuration is unchanged.
- R6: While cfgEn is low, values on cfgTable and cfgRegSel have no effect on the outputs.
- R7: A configuration applied with cfgEn high takes effect at the next rising edge. Before that edge the outputs still reflect the old contents.
- R8: A table column filled with zeros yields a constant 0 on its output for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output flip-flops and the configuration storage use its rising edge |
| rst | input | 1 | Synchronous reset of the output flip-flops |
| cfgEn | input | 1 | Configuration write enable |
| cfgTable | input | 16 | Table contents to store: word k sits in bits [2k+1:2k] |
| cfgRegSel | input | 2 | Path select to store, one bit per output: 1 = registered, 0 = direct |
| lutIn | input | 3 | Logic inputs that form the table address |
| blockOut | output | 2 | Cell outputs |

## Verification
The hardest case to reach is a registered output that must show the table word for the previous address, not the current one. The bench reaches it by changing the address on every cycle of a full sweep, so consecutive addresses always differ. It repeats this sweep for every path-select combination over a series of computed table patterns, including patterns with a zeroed column. The load-timing and ignore cases are reached in two ways: the configuration bus is driven with different data while the enable is low, and the outputs are sampled on both sides of the load edge.

// File: rtl/lutPkg.sv
package lutPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;   // capture configuration this edge
    logic regClear;  // clear output flip-flops this edge
  } lutStrobes_t;

endpackage

// File: rtl/lutCtrl.sv
module lutCtrl
  import lutPkg::*;
(
  input  logic        rst,
  input  logic        cfgEn,
  output lutStrobes_t strobes
);

  always_comb begin
    strobes          = '0;
    strobes.cfgLoad  = cfgEn;
    strobes.regClear = rst;
  end

endmodule

// File: rtl/lutDatapath.sv
module lutDatapath
  import lutPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int OUT_W  = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  lutStrobes_t                     strobes,
  input  logic [(1<<ADDR_W)*OUT_W-1:0]    cfgTableIn,
  input  logic [OUT_W-1:0]                cfgSelIn,
  input  logic [ADDR_W-1:0]               lutIn,
  output logic [OUT_W-1:0]                blockOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][OUT_W-1:0] tableMem;
  logic [OUT_W-1:0]            selMem;
  logic [OUT_W-1:0]            lutWord;
  logic [OUT_W-1:0]            regQ;

  // Configuration storage, written only on a load strobe
  always_ff @(posedge clk) begin
    if (strobes.cfgLoad) begin
      tableMem <= cfgTableIn;
      selMem   <= cfgSelIn;
    end
  end

  // Combinational lookup
  assign lutWord = tableMem[lutIn];

  // Output flip-flops
  always_ff @(posedge clk) begin
    if (strobes.regClear) regQ <= '0;
    else                  regQ <= lutWord;
  end

  // Per-output path select
  for (genvar i = 0; i < OUT_W; i++) begin : gOutMux
    assign blockOut[i] = selMem[i] ? regQ[i] : lutWord[i];
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobes.cfgLoad |=> ($stable(tableMem) && $stable(selMem))); // R6

  AST_CFG_TAKE: assert property (@(posedge clk) disable iff (rst)
    strobes.cfgLoad |=> (tableMem == $past(cfgTableIn))); // R7

  AST_REG_CLEAR: assert property (@(posedge clk)
    strobes.regClear |=> (regQ == '0)); // R5

  AST_REG_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !strobes.regClear |=> (regQ == $past(lutWord))); // R3

endmodule

// File: rtl/cfgLutCell.sv
module cfgLutCell
  import lutPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int OUT_W  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfgEn,
  input  logic [(1<<ADDR_W)*OUT_W-1:0]  cfgTable,
  input  logic [OUT_W-1:0]              cfgRegSel,
  input  logic [ADDR_W-1:0]             lutIn,
  output logic [OUT_W-1:0]              blockOut
);

  lutStrobes_t strobes;

  lutCtrl uCtrl (
    .rst     (rst),
    .cfgEn   (cfgEn),
    .strobes (strobes)
  );

  lutDatapath #(
    .ADDR_W (ADDR_W),
    .OUT_W  (OUT_W)
  ) uDp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .cfgTableIn (cfgTable),
    .cfgSelIn   (cfgRegSel),
    .lutIn      (lutIn),
    .blockOut   (blockOut)
  );

endmodule

// File: tb/tb_cfgLutCell.sv
module tb_cfgLutCell;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfgEn;
  logic [15:0] cfgTable;
  logic [1:0]  cfgRegSel;
  logic [2:0]  lutIn;
  logic [1:0]  blockOut;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgLutCell dut (
    .clk       (clk),
    .rst       (rst),
    .cfgEn     (cfgEn),
    .cfgTable  (cfgTable),
    .cfgRegSel (cfgRegSel),
    .lutIn     (lutIn),
    .blockOut  (blockOut)
  );

  function automatic logic [15:0] makeTable(int n);
    logic [15:0] v;
    v = 16'(n * 16'h9E37) ^ 16'(n << 7) ^ 16'h3C5A;
    if (n % 5 == 1) v = v & 16'h5555;  // column 1 zero
    if (n % 5 == 3) v = v & 16'hAAAA;  // column 0 zero
    return v;
  endfunction

  function automatic logic expBit(logic [15:0] t, logic [2:0] a, int j);
    return t[2*a + j];
  endfunction

  task automatic checkBit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Load a configuration; it takes effect at the following rising edge
  task automatic loadCfg(logic [15:0] t, logic [1:0] s);
    @(negedge clk);
    cfgEn = 1'b1; cfgTable = t; cfgRegSel = s;
    @(negedge clk);
    cfgEn = 1'b0;
  endtask

  // Sweep all addresses, changing every cycle, checking both outputs
  task automatic sweep(logic [15:0] t, logic [1:0] s, string req);
    logic [2:0] prev;
    @(negedge clk);
    lutIn = 3'd5;
    prev  = 3'd5;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] a;
      a = 3'((k * 3 + 1) % 8);
      @(negedge clk);
      lutIn = a;
      #1;
      for (int j = 0; j < 2; j++) begin
        if (s[j]) checkBit({req, " R3 registered"}, blockOut[j], expBit(t, prev, j));
        else      checkBit({req, " R2 direct"},     blockOut[j], expBit(t, a, j));
      end
      prev = a;
    end
  endtask

  initial begin
    logic [15:0] t;
    logic [15:0] tOld;
    rst = 1'b1; cfgEn = 1'b0; cfgTable = '0; cfgRegSel = '0; lutIn = '0;
    // Reset state: both outputs registered, cleared during reset (R5)
    loadCfg(16'hFFFF, 2'b11);
    @(negedge clk); #1;
    checkBit("R5 reset out0", blockOut[0], 1'b0);
    checkBit("R5 reset out1", blockOut[1], 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // Main sweeps: R1, R2, R3, R4, R8
    for (int n = 0; n < 20; n++) begin
      t = makeTable(n);
      for (int s = 0; s < 4; s++) begin
        loadCfg(t, 2'(s));
        sweep(t, 2'(s), (n % 5 == 1 || n % 5 == 3) ? "R8 R4 R1" : "R4 R1");
      end
    end

    // R6: bus changes with enable low are ignored
    t = makeTable(7);
    loadCfg(t, 2'b00);
    @(negedge clk);
    cfgTable = ~t; cfgRegSel = 2'b11;
    sweep(t, 2'b00, "R6 ignore");

    // R7: old contents before the load edge, new after
    tOld = t;
    t = makeTable(11);
    @(negedge clk);
    lutIn = 3'd6;
    cfgEn = 1'b1; cfgTable = t; cfgRegSel = 2'b00;
    #1;
    checkBit("R7 before edge out0", blockOut[0], expBit(tOld, 3'd6, 0));
    checkBit("R7 before edge out1", blockOut[1], expBit(tOld, 3'd6, 1));
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    checkBit("R7 after edge out0", blockOut[0], expBit(t, 3'd6, 0));
    checkBit("R7 after edge out1", blockOut[1], expBit(t, 3'd6, 1));

    // R5 mid-run: out0 registered, out1 direct; table all ones
    loadCfg(16'hFFFF, 2'b01);
    @(negedge clk); lutIn = 3'd2;
    @(negedge clk); #1;
    checkBit("R5 pre-reset out0", blockOut[0], 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    checkBit("R5 cleared out0", blockOut[0], 1'b0);
    checkBit("R5 direct out1", blockOut[1], 1'b1);
    rst = 1'b0;
    @(negedge clk); #1;
    checkBit("R5 config kept out0", blockOut[0], 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule